// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup path of a direct-mapped, write-back L1 data cache. The set index and the word select come only from the untranslated low bits of the virtual address. The tag and data arrays can therefore be read in the same cycle that the TLB starts translating the page number. One cycle later the stored tag is compared with the physical page number that the TLB returns. Several virtual names for one physical line always select the same set, so no alias can sit in two places in the array.

A request carries a virtual address, a read/write flag and a 32-bit write word. The TLB answers with a hit flag and a page number. A cache miss on a dirty line first sends the old line out through the write-back port, at the address rebuilt from the stored tag and the index. After that, the line refill port fetches the new line. The line is installed clean and the access is replayed against it. By default there are 1024 sets of 64-byte lines and 64 KB pages. An elaboration check refuses any set count and line size whose index and offset bits together reach above the page offset. When they stop short of the page offset, the remaining untranslated bits are appended to the stored tag.

Top module: `vipt_lookup`

## Requirements
- R1: The set index is vaddr[15:6] and the word select is vaddr[5:2]. Two virtual addresses that differ only in bits 31..16 and translate to the same page number reach the same line and hit.
- R2: An access hits only when its set holds a valid line whose stored tag equals the page number from translation. A line in the same set with a different page number is a miss.
- R3: A read hit raises rsp_valid with the addressed word exactly one cycle after the cycle in which tlb_hit was high.
- R4: While tlb_hit is low the request is held. No response, write-back or refill is produced, and tlb_vpn shows the held page number. No cache state changes.
- R5: A write hit replaces the addressed word and marks the line dirty. The written data leaves the cache only through a write-back when the line is evicted.
- R6: A miss on a valid dirty line first raises wb_valid. It carries wb_addr = {stored page number, index, 6'b0} and the old line, and both are held until wb_ready. Only then is the refill requested.
- R7: A miss on an invalid or clean line issues no write-back and goes straight to refill.
- R8: Reset clears every valid and dirty bit and leaves the block idle (req_ready high; rsp_valid, wb_valid and fill_req low). The first access to any set after reset misses without a write-back.
- R9: A refill raises fill_req with fill_addr = {page number, index, 6'b0}, held until fill_valid. The line is installed clean under that tag, and the access then completes from the filled line.
- R10: Only one request is in flight. req_ready is high only when idle, and req_valid asserted while busy is ignored.
- R11: A write miss refills the line, then merges the write word and marks the line dirty, so a later eviction writes that word back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| tlb_vpn | output | 16 | Page number of the request being translated |
| tlb_hit | input | 1 | Translation valid this cycle |
| tlb_ppn | input | 16 | Physical page number |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | 32 | Read word (write word on a write) |
| wb_valid | output | 1 | Evicted dirty line offered |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | 32 | Physical line address of evicted line |
| wb_data | output | 512 | Evicted line |
| fill_req | output | 1 | Refill requested |
| fill_addr | output | 32 | Physical line address to fetch |
| fill_valid | input | 1 | Refill line present |
| fill_data | input | 512 | Refill line |

## Verification
Some properties are checked on every cycle: the dirty bits stay a subset of the valid bits, a dirty mark lands only on a valid line, and a pending write-back or refill keeps its address stable until it is accepted. The same cycle-by-cycle checks cover a stalled translation staying silent, a write-back always being followed by a refill, and the fixed one-cycle read-hit latency. The bench scenarios are needed for the rest. They show that virtual aliases such as 0xFFFFFFFC and 0xEEEEFFFC share a line, that a dirty victim's written word reaches the write-back port at the rebuilt address, that a write miss ends dirty, and that reset drops lines that were dirty before it.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_RELOAD,
        ST_RECHECK,
        ST_RESP
    } vipt_state_e;
endpackage

// File: rtl/vipt_addr_split.sv
module vipt_addr_split #(
    parameter int VA_W       = 32,
    parameter int PAGE_BITS  = 16,
    parameter int SETS       = 1024,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int WB_W   = $clog2(vipt_pkg::WORD_BYTES),
    localparam int WSEL_W = OFF_W - WB_W,
    localparam int GAP_W  = PAGE_BITS - IDX_W - OFF_W,
    localparam int GAP_P  = (GAP_W > 0) ? GAP_W : 1,
    localparam int VPN_W  = VA_W - PAGE_BITS
) (
    input  logic [VA_W-1:0]   vaddr,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] wsel,
    output logic [GAP_P-1:0]  gap,
    output logic [VPN_W-1:0]  vpn
);
    // Index and word select come only from untranslated bits.
    assign idx  = vaddr[OFF_W +: IDX_W];
    assign wsel = vaddr[WB_W +: WSEL_W];
    assign vpn  = vaddr[VA_W-1 -: VPN_W];

    logic unused_byte_bits;
    assign unused_byte_bits = ^vaddr[WB_W-1:0];

    generate
        if (IDX_W + OFF_W > PAGE_BITS) begin : g_bad_geometry
            $error("vipt_addr_split: index plus line offset exceeds page offset");
            assign gap = '0;
        end else if (GAP_W > 0) begin : g_gap
            assign gap = vaddr[PAGE_BITS-1 -: GAP_W];
        end else begin : g_nogap
            assign gap = '0;
        end
    endgenerate
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SETS  = 1024,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] raddr,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic [IDX_W-1:0] waddr,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             set_dirty
);
    logic [TAG_W-1:0] tags_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= '0;
            dirty_q  <= '0;
            rd_valid <= 1'b0;
            rd_dirty <= 1'b0;
        end else begin
            if (fill_en) begin
                valid_q[waddr] <= 1'b1;
                dirty_q[waddr] <= 1'b0;
            end else if (set_dirty) begin
                dirty_q[waddr] <= 1'b1;
            end
            rd_valid <= valid_q[raddr];
            rd_dirty <= dirty_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tags_q[waddr] <= fill_tag;
        rd_tag <= tags_q[raddr];
    end

    // R5: no set is ever dirty without being valid
    p_dirty_subset_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);

    // R5: a dirty mark only lands on a line that is present
    p_mark_on_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_dirty |-> valid_q[waddr]);
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int SETS   = 1024,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  raddr,
    output logic [LINE_W-1:0] rd_line,
    input  logic [IDX_W-1:0]  waddr,
    input  logic              line_en,
    input  logic [LINE_W-1:0] line_in,
    input  logic              word_en,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [WORD_W-1:0] word_in
);
    logic [LINE_W-1:0] mem_q [SETS];

    always_ff @(posedge clk) begin
        if (line_en) begin
            mem_q[waddr] <= line_in;
        end else if (word_en) begin
            mem_q[waddr][wsel*WORD_W +: WORD_W] <= word_in;
        end
        rd_line <= mem_q[raddr];
    end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BITS  = 16,
    parameter int SETS       = 1024,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = OFF_W - $clog2(WORD_BYTES),
    localparam int GAP_W  = PAGE_BITS - IDX_W - OFF_W,
    localparam int GAP_P  = (GAP_W > 0) ? GAP_W : 1,
    localparam int PPN_W  = PA_W - PAGE_BITS,
    localparam int VPN_W  = VA_W - PAGE_BITS,
    localparam int TAG_W  = PPN_W + ((GAP_W > 0) ? GAP_W : 0),
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [VPN_W-1:0]  tlb_vpn,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [PA_W-1:0]   wb_addr,
    output logic [LINE_W-1:0] wb_data,
    output logic              fill_req,
    output logic [PA_W-1:0]   fill_addr,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_data
);
    typedef struct packed {
        vipt_state_e       state;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [GAP_P-1:0]  gap;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic              write;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic [GAP_P-1:0]  req_gap;
    logic [VPN_W-1:0]  req_vpn;

    vipt_addr_split #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SETS(SETS), .LINE_BYTES(LINE_BYTES)
    ) split_i (
        .vaddr(req_vaddr), .idx(req_idx), .wsel(req_wsel), .gap(req_gap), .vpn(req_vpn)
    );

    logic [IDX_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid, rd_dirty;
    logic [LINE_W-1:0] rd_line;
    logic              fill_en_d, set_dirty_d, word_en_d;
    logic [PPN_W-1:0]  cmp_ppn;
    logic [TAG_W-1:0]  cmp_tag;
    logic              lookup_hit;
    logic              translated;

    // Compare against the live translation in LOOKUP, else the captured page number.
    assign cmp_ppn = (ctl_q.state == ST_LOOKUP) ? tlb_ppn : ctl_q.ppn;

    generate
        if (GAP_W > 0) begin : g_tag_gap
            assign cmp_tag = {cmp_ppn, ctl_q.gap[GAP_W-1:0]};
        end else begin : g_tag_ppn
            logic unused_gap;
            assign unused_gap = ^ctl_q.gap;
            assign cmp_tag = cmp_ppn;
        end
    endgenerate

    assign lookup_hit = rd_valid && (rd_tag == cmp_tag);
    assign translated = (ctl_q.state == ST_RECHECK) ||
                        ((ctl_q.state == ST_LOOKUP) && tlb_hit);

    // Array read starts in the accept cycle, alongside the translation.
    assign rd_idx = (ctl_q.state == ST_IDLE && req_valid) ? req_idx : ctl_q.idx;

    always_comb begin
        ctl_d       = ctl_q;
        fill_en_d   = 1'b0;
        set_dirty_d = 1'b0;
        word_en_d   = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.idx   = req_idx;
                    ctl_d.wsel  = req_wsel;
                    ctl_d.gap   = req_gap;
                    ctl_d.vpn   = req_vpn;
                    ctl_d.write = req_write;
                    ctl_d.wdata = req_wdata;
                    ctl_d.state = ST_LOOKUP;
                end
            end
            ST_LOOKUP, ST_RECHECK: begin
                if (translated) begin
                    ctl_d.ppn = cmp_ppn;
                    if (lookup_hit) begin
                        if (ctl_q.write) begin
                            word_en_d   = 1'b1;
                            set_dirty_d = 1'b1;
                            ctl_d.rdata = ctl_q.wdata;
                        end else begin
                            ctl_d.rdata = rd_line[ctl_q.wsel*WORD_W +: WORD_W];
                        end
                        ctl_d.state = ST_RESP;
                    end else if (rd_valid && rd_dirty) begin
                        ctl_d.state = ST_WBACK;
                    end else begin
                        ctl_d.state = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (wb_ready) ctl_d.state = ST_FILL;
            end
            ST_FILL: begin
                if (fill_valid) begin
                    fill_en_d   = 1'b1;
                    ctl_d.state = ST_RELOAD;
                end
            end
            ST_RELOAD: ctl_d.state = ST_RECHECK;
            ST_RESP:   ctl_d.state = ST_IDLE;
            default:   ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    vipt_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n), .raddr(rd_idx),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .waddr(ctl_q.idx), .fill_en(fill_en_d), .fill_tag(cmp_tag),
        .set_dirty(set_dirty_d)
    );

    vipt_data_store #(.SETS(SETS), .LINE_W(LINE_W), .WORD_W(WORD_W)) data_i (
        .clk(clk), .raddr(rd_idx), .rd_line(rd_line),
        .waddr(ctl_q.idx), .line_en(fill_en_d), .line_in(fill_data),
        .word_en(word_en_d), .wsel(ctl_q.wsel), .word_in(ctl_q.wdata)
    );

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign rsp_valid = (ctl_q.state == ST_RESP);
    assign rsp_rdata = ctl_q.rdata;
    assign tlb_vpn   = ctl_q.vpn;
    assign wb_valid  = (ctl_q.state == ST_WBACK);
    assign wb_addr   = {rd_tag, ctl_q.idx, {OFF_W{1'b0}}};
    assign wb_data   = rd_line;
    assign fill_req  = (ctl_q.state == ST_FILL);
    assign fill_addr = {cmp_tag, ctl_q.idx, {OFF_W{1'b0}}};

    // R3: a translated read hit answers on the next cycle
    p_read_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOOKUP && tlb_hit && lookup_hit && !ctl_q.write) |=> rsp_valid);

    // R4: a pending translation keeps every outgoing request quiet
    p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOOKUP && !tlb_hit) |=> (!rsp_valid && !wb_valid && !fill_req));

    // R6: an offered victim and its address hold until taken
    p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

    // R6: a finished write-back is followed by a refill request
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_valid) |-> fill_req);

    // R9: refill request and address hold until the line arrives
    p_fill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

    // R10: no new request is taken while one is in flight
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || wb_valid || fill_req) |-> !req_ready);
endmodule

// File: tb/vipt_lookup_tb_top.sv
module vipt_lookup_tb_top;
    localparam int CLK_NS = 20;

    typedef struct packed {
        logic        wr;
        logic [31:0] va;
        logic [31:0] wd;
        logic [15:0] ppn;
        logic        ewb;
        logic [31:0] wbpa;
        logic [3:0]  wbsel;
        logic [31:0] wbword;
        logic        efill;
        logic [31:0] fillpa;
        logic        crd;
        logic [31:0] erd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R8 R7 R9: cold read miss, refill only
        '{1'b0, 32'h0000_1040, 32'h0, 16'h0001, 1'b0, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0001_1040, 1'b1, 32'h5A5B_1040},
        // R2 R3: read hit, other word
        '{1'b0, 32'h0000_1044, 32'h0, 16'h0001, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h5A5B_1044},
        // R5: write hit
        '{1'b1, 32'h0000_1048, 32'hDEAD_BEEF, 16'h0001, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0},
        // R5: read back written word
        '{1'b0, 32'h0000_1048, 32'h0, 16'h0001, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b1, 32'hDEAD_BEEF},
        // R1: alias virtual page, same physical page
        '{1'b0, 32'h7777_1048, 32'h0, 16'h0001, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b1, 32'hDEAD_BEEF},
        // R6 R2: same set, other page, dirty victim
        '{1'b0, 32'h0000_1048, 32'h0, 16'h0002, 1'b1, 32'h0001_1040, 4'h2, 32'hDEAD_BEEF, 1'b1, 32'h0002_1040, 1'b1, 32'h5A58_1048},
        // R1: top set, top word
        '{1'b0, 32'hFFFF_FFFC, 32'h0, 16'h0003, 1'b0, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0003_FFC0, 1'b1, 32'h5A59_FFFC},
        // R1: alias of the above hits
        '{1'b0, 32'hEEEE_FFFC, 32'h0, 16'h0003, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h5A59_FFFC},
        // R11: write miss refills then merges
        '{1'b1, 32'h0000_2000, 32'h1234_5678, 16'h0004, 1'b0, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0004_2000, 1'b0, 32'h0},
        // R11: merged word visible
        '{1'b0, 32'h0000_2000, 32'h0, 16'h0004, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1234_5678},
        // R11 R5: eviction carries the merged word
        '{1'b0, 32'h0000_2004, 32'h0, 16'h0005, 1'b1, 32'h0004_2000, 4'h0, 32'h1234_5678, 1'b1, 32'h0005_2000, 1'b1, 32'h5A5F_2004},
        // R9 R7: refilled line is clean, no write-back
        '{1'b0, 32'h0000_2000, 32'h0, 16'h0004, 1'b0, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0004_2000, 1'b1, 32'h5A5E_2000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_vaddr = '0;
    logic         req_write = 1'b0;
    logic [31:0]  req_wdata = '0;
    logic [15:0]  tlb_vpn;
    logic         tlb_hit = 1'b0;
    logic [15:0]  tlb_ppn = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         wb_valid;
    logic         wb_ready = 1'b0;
    logic [31:0]  wb_addr;
    logic [511:0] wb_data;
    logic         fill_req;
    logic [31:0]  fill_addr;
    logic         fill_valid = 1'b0;
    logic [511:0] fill_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_NS/2) clk = ~clk;

    vipt_lookup dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_wdata(req_wdata),
        .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Memory model: each word holds its own physical address xor a constant.
    function automatic logic [511:0] mem_line(input logic [31:0] pa);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = (pa + 32'(w*4)) ^ 32'h5A5A_0000;
        return l;
    endfunction

    task automatic do_access(input string tag, input vec_t v, input int stall, input logic [31:0] alt_va);
        int wb_seen = 0, fill_seen = 0, wb_it = -1, fill_it = -1, lat = -1;
        logic [31:0] wb_pa = '0, wb_w = '0, fill_pa = '0, rd = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = v.va; req_write = v.wr; req_wdata = v.wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int s = 0; s < stall; s++) begin
            tlb_hit = 1'b0;
            req_valid = 1'b1; req_vaddr = alt_va; req_write = 1'b1; // R10: must be ignored
            @(posedge clk); @(negedge clk);
            chk("R4", "stall rsp_valid", {31'b0, rsp_valid}, 32'd0);
            chk("R4", "stall wb/fill", {30'b0, wb_valid, fill_req}, 32'd0);
            chk("R4", "stall tlb_vpn", {16'b0, tlb_vpn}, {16'b0, v.va[31:16]});
            chk("R10", "stall req_ready", {31'b0, req_ready}, 32'd0);
        end
        req_valid = 1'b0; req_write = 1'b0;
        tlb_hit = 1'b1; tlb_ppn = v.ppn;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); @(negedge clk);
            wb_ready = 1'b0; fill_valid = 1'b0;
            if (rsp_valid) begin
                rd = rsp_rdata; lat = i;
                break;
            end
            if (wb_valid) begin
                wb_seen++; wb_it = i; wb_pa = wb_addr; wb_w = wb_data[v.wbsel*32 +: 32];
                wb_ready = 1'b1;
            end
            if (fill_req) begin
                fill_seen++; fill_it = i; fill_pa = fill_addr;
                fill_data = mem_line(fill_addr); fill_valid = 1'b1;
            end
        end
        tlb_hit = 1'b0;
        chk(tag, "completed", {31'b0, lat >= 0}, 32'd1);
        chk("R6/R7", "write-back issued", {31'b0, wb_seen > 0}, {31'b0, v.ewb});
        if (v.ewb) begin
            chk("R6", "wb_addr", wb_pa, v.wbpa);
            chk("R5", "evicted word", wb_w, v.wbword);
            chk("R6", "write-back before refill", {31'b0, wb_it < fill_it}, 32'd1);
        end
        chk("R9", "refill issued", {31'b0, fill_seen > 0}, {31'b0, v.efill});
        if (v.efill) chk("R9", "fill_addr", fill_pa, v.fillpa);
        if (v.crd) chk(tag, "read data R2", rd, v.erd);
        if (!v.ewb && !v.efill) chk("R3", "hit latency", 32'(lat), 32'd0);
    endtask

    initial begin
        do_reset();
        // R8: idle after reset
        chk("R8", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R8", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R8", "wb_valid/fill_req", {30'b0, wb_valid, fill_req}, 32'd0);

        for (int k = 0; k < NV; k++) do_access($sformatf("vec%0d", k), VECS[k], 0, 32'h0);

        // R4 R10: translation stall with a competing request, then a hit on ppn 2
        do_access("R4", '{1'b0, 32'h0000_1044, 32'h0, 16'h0002, 1'b0, 32'h0, 4'h0, 32'h0,
                          1'b0, 32'h0, 1'b1, 32'h5A58_1044}, 4, 32'h0000_2008);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); @(negedge clk);
            chk("R10", "no second response", {31'b0, rsp_valid}, 32'd0);
        end
        // R10: the ignored write did not land in set 0x80
        do_access("R10", '{1'b0, 32'h0000_2008, 32'h0, 16'h0004, 1'b0, 32'h0, 4'h0, 32'h0,
                           1'b0, 32'h0, 1'b1, 32'h5A5E_2008}, 0, 32'h0);

        // R8: dirty line before reset is forgotten afterwards
        do_access("R5", '{1'b1, 32'h0000_1044, 32'hCAFE_0001, 16'h0002, 1'b0, 32'h0, 4'h0, 32'h0,
                          1'b0, 32'h0, 1'b0, 32'h0}, 0, 32'h0);
        do_reset();
        do_access("R8", '{1'b0, 32'h0000_1044, 32'h0, 16'h0002, 1'b0, 32'h0, 4'h0, 32'h0,
                          1'b1, 32'h0002_1040, 1'b1, 32'h5A58_1044}, 0, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule